// File: doc/BRIEF.md
# CRC32C Accumulate Unit

This execution-unit slice folds one data operand into a running 32-bit Castagnoli checksum. Each issued operation carries a 32-bit accumulator, a 64-bit data word and a 2-bit size code. The size code selects how many low-order data bits take part: 8, 16, 32 or 64. One clock later the block returns the updated accumulator.

The checksum is the bit-reflected form of the generator polynomial 0x1EDC6F41. The datapath is an LSB-first shift register that uses the reflected constant 0x82F63B78 and is unrolled once per data bit. The block applies no initial preset and no final inversion, and it produces no flags. Software seeds the accumulator and inverts the final value itself. Longer messages are handled by feeding each result back as the next accumulator.

Top module: `crc32c_accum`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_acc` are 0 after that edge.
- R2: `out_valid` is high after a clock edge exactly when `in_valid` was high at that edge with `rst` low.
- R3: Following an edge at which `in_valid` is low, `out_acc` keeps its previous value whatever the other inputs carry.
- R4: Size code 2'b00 (byte) folds `in_data[7:0]` only. Bits 63:8 have no effect on the result.
- R5: Size code 2'b01 (halfword) folds `in_data[15:0]` only. Bits 63:16 have no effect on the result.
- R6: Size code 2'b10 (word) folds `in_data[31:0]` only. Bits 63:32 have no effect on the result.
- R7: Size code 2'b11 (doubleword) folds all 64 bits of `in_data`.
- R8: The result equals the reversal of ((reversed accumulator followed by n zero bits) XOR (data reversed across n bits followed by 32 zero bits)) mod 0x1EDC6F41, where n is the selected size.
- R9: Byte-wise folding of the ASCII string "123456789" from accumulator 0xFFFFFFFF, followed by inversion, gives 0xE3069283.
- R10: One doubleword fold gives the same accumulator as eight byte folds of the same operand, taken least-significant byte first.
- R11: An all-zero accumulator with all-zero data gives an all-zero result in every size, because no preset and no final XOR are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_acc | input | 32 | Incoming checksum accumulator |
| in_data | input | 64 | Data operand, low bits used for narrow sizes |
| in_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 doubleword |
| out_valid | output | 1 | Result available |
| out_acc | output | 32 | Updated checksum accumulator |

## Verification
Every result is due exactly one rising edge after its issue, because the only register on the path is the output stage. The driver changes inputs on falling edges and pushes a model value into a queue at that moment. The monitor samples 2 ns after each rising edge, and whenever `out_valid` is high it pops exactly one item. A result that arrives late, early or unrequested therefore breaks the ordering and shows up as a mismatch or as an empty-queue failure. Hold behaviour is checked on the cycle after an idle edge, with junk on the data and size inputs.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

   typedef enum logic [1:0] {
      FOLD_BYTE  = 2'b00,
      FOLD_HALF  = 2'b01,
      FOLD_WORD  = 2'b10,
      FOLD_DWORD = 2'b11
   } fold_size_e;

   localparam logic [31:0] CASTAGNOLI_NORMAL = 32'h1EDC6F41;

   function automatic logic [31:0] mirror32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   localparam logic [31:0] CASTAGNOLI_REFL = mirror32(CASTAGNOLI_NORMAL);

endpackage

// File: rtl/crc32c_fold.sv
module crc32c_fold #(
   parameter int                ACC_W  = 32,
   parameter int                BITS   = 8,
   parameter logic [ACC_W-1:0]  POLY_R = '0
) (
   input  logic [ACC_W-1:0] acc_i,
   input  logic [BITS-1:0]  data_i,
   output logic [ACC_W-1:0] acc_o
);

   if (BITS < 1) begin : g_bad_bits
      $error("crc32c_fold: BITS must be positive");
   end

   always_comb begin
      logic [ACC_W-1:0] c;
      logic             fb;
      c = acc_i;
      for (int i = 0; i < BITS; i++) begin
         fb = c[0] ^ data_i[i];
         c  = (c >> 1) ^ ({ACC_W{fb}} & POLY_R);
      end
      acc_o = c;
   end

endmodule

// File: rtl/crc32c_lane_sel.sv
module crc32c_lane_sel #(
   parameter int ACC_W   = 32,
   parameter int LANES   = 4,
   localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0][ACC_W-1:0] lane_i,
   input  logic [SEL_W-1:0]            sel_i,
   output logic [ACC_W-1:0]            res_o
);

   always_comb begin
      res_o = lane_i[0];
      for (int k = 0; k < LANES; k++) begin
         if (SEL_W'(k) == sel_i) res_o = lane_i[k];
      end
   end

endmodule

// File: rtl/crc32c_accum.sv
module crc32c_accum
   import crc32c_pkg::*;
#(
   parameter int          ACC_W   = 32,
   parameter int          DATA_W  = 64,
   parameter int          MIN_W   = 8,
   parameter logic [31:0] POLY_R  = CASTAGNOLI_REFL,
   localparam int         LANES   = $clog2(DATA_W / MIN_W) + 1,
   localparam int         SEL_W   = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [ACC_W-1:0]  in_acc,
   input  logic [DATA_W-1:0] in_data,
   input  logic [SEL_W-1:0]  in_size,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_acc
);

   if (ACC_W != 32) begin : g_bad_acc
      $error("crc32c_accum: ACC_W must be 32");
   end
   if ((MIN_W << (LANES - 1)) != DATA_W) begin : g_bad_data
      $error("crc32c_accum: DATA_W must be MIN_W times a power of two");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("crc32c_accum: size code is defined for four lanes");
   end

   logic [LANES-1:0][ACC_W-1:0] lane_res;
   logic [ACC_W-1:0]            next_acc;
   logic                        vld_q;
   logic [ACC_W-1:0]            acc_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LB = MIN_W << g;
      crc32c_fold #(
         .ACC_W  (ACC_W),
         .BITS   (LB),
         .POLY_R (POLY_R[ACC_W-1:0])
      ) u_fold (
         .acc_i  (in_acc),
         .data_i (in_data[LB-1:0]),
         .acc_o  (lane_res[g])
      );
   end

   crc32c_lane_sel #(
      .ACC_W (ACC_W),
      .LANES (LANES)
   ) u_sel (
      .lane_i (lane_res),
      .sel_i  (in_size),
      .res_o  (next_acc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         acc_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) acc_q <= next_acc;
      end
   end

   assign out_valid = vld_q;
   assign out_acc   = acc_q;

   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && out_acc == '0));

   // R2
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R3
   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_acc));

   // R11
   a_r11_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_acc == '0 && in_data == '0) |=> (out_acc == '0));

   // R4
   a_r4_byte_ignores_high: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_size == SEL_W'(FOLD_BYTE) && in_acc == '0
       && in_data[MIN_W-1:0] == '0) |=> (out_acc == '0));

endmodule

// File: tb/sim_crc32c_accum.sv
module sim_crc32c_accum;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_acc = '0;
   logic [63:0] in_data = '0;
   logic [1:0]  in_size = '0;
   logic        out_valid;
   logic [31:0] out_acc;

   always #5 clk = ~clk;

   crc32c_accum u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
      .in_data(in_data), .in_size(in_size),
      .out_valid(out_valid), .out_acc(out_acc)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] last_out = '0;

   function automatic logic [31:0] rev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   // Model: reflect, long division MSB-first by the normal polynomial, reflect
   function automatic logic [31:0] model(input logic [31:0] acc,
                                         input logic [63:0] d, input int n);
      logic [31:0] r;
      logic        fb;
      r = rev32(acc);
      for (int i = 0; i < n; i++) begin
         fb = r[31] ^ d[i];
         r  = {r[30:0], 1'b0};
         if (fb) r = r ^ 32'h1EDC6F41;
      end
      return rev32(r);
   endfunction

   function automatic int nbits(input logic [1:0] s);
      return 8 << s;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] a, input logic [63:0] d,
                       input logic [1:0] s, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_acc = a; in_data = d; in_size = s;
      exp_q.push_back(model(a, d, nbits(s)));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_acc   = 32'hA5A5_0000 + k;
         in_data  = 64'hFEED_FACE_0BAD_F00D ^ 64'(k);
         in_size  = 2'(k);
      end
   endtask

   // Monitor: each valid result pops one expected item
   always @(posedge clk) begin
      #2;
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected out_valid", out_acc, 32'h0);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_acc === e, t, out_acc, e);
         end
         last_out = out_acc;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      logic [31:0] a;
      logic [31:0] held;
      logic [31:0] dres;
      logic [63:0] v;

      // R1: reset with in_valid asserted
      in_valid = 1'b1; in_acc = 32'h1234_5678; in_data = 64'h1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'h0);
      check(out_acc == 32'h0, "R1 out_acc in reset", out_acc, 32'h0);
      in_valid = 1'b0;
      rst = 1'b0;
      idle(2);
      check(out_valid == 1'b0, "R2 idle keeps out_valid low", 32'(out_valid), 32'h0);

      // R4: byte mode with junk in bits 63:8
      send(32'h0, 64'hDEAD_BEEF_CAFE_1200 | 64'h31, 2'b00, "R4 byte ignores high bits");
      send(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FF00, 2'b00, "R4 byte zero low bits");
      // R5 / R6 / R7: other sizes, junk above the used field
      send(32'h1357_9BDF, 64'h7777_8888_9999_ABCD, 2'b01, "R5 halfword");
      send(32'h0BAD_CAFE, 64'h5555_AAAA_0123_4567, 2'b10, "R6 word");
      send(32'hFFFF_FFFF, 64'h0123_4567_89AB_CDEF, 2'b11, "R7 doubleword");
      send(32'h8000_0001, 64'h8000_0000_0000_0001, 2'b11, "R8 edge bits doubleword");
      // R11: zero in, zero out in every size
      for (int s = 0; s < 4; s++) send(32'h0, 64'h0, 2'(s), "R11 zero stays zero");
      idle(1);

      // R3: hold after idle with junk inputs
      idle(1);
      held = last_out;
      idle(3);
      check(out_acc === held, "R3 hold while idle", out_acc, held);
      check(out_valid == 1'b0, "R2 low after idle", 32'(out_valid), 32'h0);

      // R9: check string, back-to-back byte folds
      a = 32'hFFFF_FFFF;
      for (int k = 1; k <= 9; k++) begin
         send(a, 64'hABCD_0000_0000_0000 | 64'(8'h30 + k), 2'b00, "R9 check string step");
         a = model(a, 64'(8'h30 + k), 8);
      end
      idle(2);
      check(~last_out === 32'hE306_9283, "R9 check value", ~last_out, 32'hE306_9283);

      // R10: doubleword vs eight bytes
      v = 64'hC0FF_EE15_600D_D00D;
      send(32'h0F0F_1234, v, 2'b11, "R10 doubleword pass");
      idle(2);
      dres = last_out;
      a = 32'h0F0F_1234;
      for (int k = 0; k < 8; k++) begin
         send(a, v >> (8 * k), 2'b00, "R10 byte pass step");
         a = model(a, v >> (8 * k), 8);
      end
      idle(2);
      check(last_out === dres, "R10 dword equals bytes", last_out, dres);

      // R1: reset in mid-stream clears output
      send(32'h1111_2222, 64'h33, 2'b00, "R2 before reset");
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(out_acc == 32'h0 && !out_valid, "R1 reset mid-run", out_acc, 32'h0);
      rst = 1'b0;
      idle(2);
      check(exp_q.size() == 0, "R2 all results delivered",
            32'(exp_q.size()), 32'h0);
      finish_run();
   end

endmodule